// File: doc/BRIEF.md
# Two-Stage Codeword Error Flag Arbiter

This block decides, for each codeword of a two-stage Reed-Solomon style decoder, whether the codeword should be corrected and what happens to its erasure flag. The caller supplies the error count from syndrome analysis and says which stage the codeword belongs to. For the second stage it also supplies the number of first-stage flags the codeword carries and whether the located error positions all agree with those flags. The block returns a 2-bit decision code, a separate fix-enable bit, and the stage the decision belongs to.

The first stage of a frame is finished before its second stage runs. First-stage decisions drive a flag register. Second-stage decisions drive the write-back to buffer memory. Syndrome computation and symbol repair are done outside this block. The block only arbitrates the policy.

A valid/ready handshake carries the inputs. Each accepted request produces one registered decision on the next clock edge. That decision is held until the consumer takes it.

Top module: `efa_flag_arbiter`

## Requirements
- R1: While reset is asserted and right after it, `out_valid` is 0, `out_code` is 2'b00 and `out_fix_en` is 0.
- R2: A request is accepted on a clock edge where `in_valid` and `in_ready` are both 1. Its decision appears with `out_valid`=1 after that edge. `in_ready` equals (not `out_valid`) or `out_ready`. While `out_valid`=1 and `out_ready`=0, the code, fix-enable and stage outputs hold steady.
- R3: Decision codes are 2'b00 pass with flag cleared, 2'b01 fix with flag cleared, 2'b10 flag raised, and 2'b11 copy first-stage flags. `in_stage`=0 selects stage 1. In stage 1, zero errors gives 2'b00. One error gives 2'b01. Two errors gives 2'b10 with a fix. Stage 1 never returns 2'b11.
- R4: In stage 1, an error count of three or more gives 2'b10 with no fix. In stage 1, `in_flag_cnt` and `in_pos_match` have no effect on any output.
- R5: In stage 2 (`in_stage`=1), zero errors gives 2'b00 and one error gives 2'b01, whatever the flag count and match inputs are.
- R6: In stage 2 with two errors and `in_pos_match`=1, the result is 2'b01 when the flag count is 6 or less, and 2'b11 when it is 7 or more.
- R7: In stage 2 with two errors and `in_pos_match`=0, the result is 2'b10 when the flag count is 5 or less, and 2'b11 when it is 6 or more.
- R8: In stage 2 with three or more errors, the result is 2'b10 when the flag count is 2 or less and 2'b11 otherwise. `in_pos_match` is ignored.
- R9: `out_fix_en` is 1 exactly for code 2'b01, and for a stage-1 two-error decision (code 2'b10). It is 0 in every other case.
- R10: `out_stage` carries the `in_stage` value of the request the decision belongs to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request |
| in_stage | input | 1 | 0 = stage 1, 1 = stage 2 |
| in_err_cnt | input | ERR_W | Error count for the codeword (saturated by the caller) |
| in_flag_cnt | input | FLAG_W | Number of stage-1 flags in the codeword (stage 2 only) |
| in_pos_match | input | 1 | All located errors sit on flagged positions (stage 2 only) |
| out_valid | output | 1 | Decision present |
| out_ready | input | 1 | Consumer takes the decision |
| out_code | output | 2 | Decision code |
| out_fix_en | output | 1 | Apply the correction |
| out_stage | output | 1 | Stage of the decision |

## Verification
The bench sweeps every error count, flag count and match value in both stages. It compares each decision against thresholds restated arithmetically. The sweep therefore reaches the exact boundaries at 2, 5/6 and 6/7 flags, where an off-by-one comparison would raise the flag when it should copy, or the reverse. It also checks that stage 1 is independent of the flag inputs. A design that leaked the stage-2 tables into stage 1 would emit copy codes there. Finally, a stalled consumer is held off while a new request waits. A design that dropped the ready gating would overwrite the held decision, and the second result would then show up early.

// File: rtl/efa_pkg.sv
package efa_pkg;

  typedef enum logic [1:0] {
    DEC_PASS = 2'b00,
    DEC_FIX  = 2'b01,
    DEC_MARK = 2'b10,
    DEC_COPY = 2'b11
  } dec_code_t;

  typedef struct packed {
    dec_code_t code;
    logic      fix_en;
    logic      stage;
  } dec_t;

endpackage

// File: rtl/efa_stage1_rule.sv
module efa_stage1_rule #(
  parameter int ERR_W = 3
) (
  input  logic [ERR_W-1:0] err_cnt,
  output efa_pkg::dec_code_t code,
  output logic               fix_en
);
  import efa_pkg::*;

  localparam logic [ERR_W-1:0] E_ONE = ERR_W'(1);
  localparam logic [ERR_W-1:0] E_TWO = ERR_W'(2);

  logic is_clean, is_single, is_double;

  assign is_clean  = (err_cnt == '0);
  assign is_single = (err_cnt == E_ONE);
  assign is_double = (err_cnt == E_TWO);

  always_comb begin
    code   = DEC_MARK;
    fix_en = 1'b0;
    if (is_clean) begin
      code = DEC_PASS;
    end else if (is_single) begin
      code   = DEC_FIX;
      fix_en = 1'b1;
    end else if (is_double) begin
      code   = DEC_MARK;
      fix_en = 1'b1;
    end
  end
endmodule

// File: rtl/efa_stage2_rule.sv
module efa_stage2_rule #(
  parameter int ERR_W             = 3,
  parameter int FLAG_W            = 5,
  parameter int MATCH_COPY_MIN    = 7,
  parameter int MISMATCH_COPY_MIN = 6,
  parameter int MANY_MARK_MAX     = 2
) (
  input  logic [ERR_W-1:0]  err_cnt,
  input  logic [FLAG_W-1:0] flag_cnt,
  input  logic              pos_match,
  output efa_pkg::dec_code_t code,
  output logic               fix_en
);
  import efa_pkg::*;

  localparam logic [ERR_W-1:0]  E_ONE   = ERR_W'(1);
  localparam logic [ERR_W-1:0]  E_TWO   = ERR_W'(2);
  localparam logic [FLAG_W-1:0] LIM_MAT = FLAG_W'(MATCH_COPY_MIN);
  localparam logic [FLAG_W-1:0] LIM_MIS = FLAG_W'(MISMATCH_COPY_MIN);
  localparam logic [FLAG_W-1:0] LIM_MNY = FLAG_W'(MANY_MARK_MAX);

  function automatic dec_code_t double_rule(input logic [FLAG_W-1:0] f,
                                            input logic m);
    if (m) return (f >= LIM_MAT) ? DEC_COPY : DEC_FIX;
    return (f >= LIM_MIS) ? DEC_COPY : DEC_MARK;
  endfunction

  function automatic dec_code_t many_rule(input logic [FLAG_W-1:0] f);
    return (f <= LIM_MNY) ? DEC_MARK : DEC_COPY;
  endfunction

  logic is_clean, is_single, is_double;

  assign is_clean  = (err_cnt == '0);
  assign is_single = (err_cnt == E_ONE);
  assign is_double = (err_cnt == E_TWO);

  always_comb begin
    if (is_clean)       code = DEC_PASS;
    else if (is_single) code = DEC_FIX;
    else if (is_double) code = double_rule(flag_cnt, pos_match);
    else                code = many_rule(flag_cnt);
    fix_en = (code == DEC_FIX);
  end
endmodule

// File: rtl/efa_out_reg.sv
module efa_out_reg (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  efa_pkg::dec_t dec_in,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output efa_pkg::dec_t dec_out,
  output logic          take
);
  import efa_pkg::*;

  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      dec_out   <= '0;
    end else if (take) begin
      rsp_valid <= 1'b1;
      dec_out   <= dec_in;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/efa_flag_arbiter.sv
module efa_flag_arbiter #(
  parameter int ERR_W             = 3,
  parameter int FLAG_W            = 5,
  parameter int MATCH_COPY_MIN    = 7,
  parameter int MISMATCH_COPY_MIN = 6,
  parameter int MANY_MARK_MAX     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_stage,
  input  logic [ERR_W-1:0]  in_err_cnt,
  input  logic [FLAG_W-1:0] in_flag_cnt,
  input  logic              in_pos_match,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_code,
  output logic              out_fix_en,
  output logic              out_stage
);
  import efa_pkg::*;

  dec_code_t s1_code, s2_code;
  logic      s1_fix, s2_fix;
  dec_t      next_dec, held_dec;
  logic      accept;
  logic      stall;

  efa_stage1_rule #(.ERR_W(ERR_W)) s1_i (
    .err_cnt(in_err_cnt),
    .code   (s1_code),
    .fix_en (s1_fix)
  );

  efa_stage2_rule #(
    .ERR_W            (ERR_W),
    .FLAG_W           (FLAG_W),
    .MATCH_COPY_MIN   (MATCH_COPY_MIN),
    .MISMATCH_COPY_MIN(MISMATCH_COPY_MIN),
    .MANY_MARK_MAX    (MANY_MARK_MAX)
  ) s2_i (
    .err_cnt  (in_err_cnt),
    .flag_cnt (in_flag_cnt),
    .pos_match(in_pos_match),
    .code     (s2_code),
    .fix_en   (s2_fix)
  );

  always_comb begin
    next_dec.stage  = in_stage;
    next_dec.code   = in_stage ? s2_code : s1_code;
    next_dec.fix_en = in_stage ? s2_fix  : s1_fix;
  end

  efa_out_reg out_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(in_valid),
    .req_ready(in_ready),
    .dec_in   (next_dec),
    .rsp_valid(out_valid),
    .rsp_ready(out_ready),
    .dec_out  (held_dec),
    .take     (accept)
  );

  assign stall      = out_valid && !out_ready;
  assign out_code   = held_dec.code;
  assign out_fix_en = held_dec.fix_en;
  assign out_stage  = held_dec.stage;
endmodule

// File: rtl/efa_flag_arbiter_chk.sv
module efa_flag_arbiter_chk #(
  parameter int ERR_W  = 3,
  parameter int FLAG_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              in_stage,
  input logic [ERR_W-1:0]  in_err_cnt,
  input logic [FLAG_W-1:0] in_flag_cnt,
  input logic              out_valid,
  input logic [1:0]        out_code,
  input logic              out_fix_en,
  input logic              out_stage,
  input logic              accept,
  input logic              stall
);
  localparam logic [ERR_W-1:0]  E_THREE = ERR_W'(3);
  localparam logic [FLAG_W-1:0] F_TWO   = FLAG_W'(2);

  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid); // R2
  AST_HOLD_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> out_valid && $stable(out_code) && $stable(out_fix_en) && $stable(out_stage)); // R2
  AST_NO_TAKE_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !in_ready); // R2
  AST_S1_NEVER_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_stage) |-> out_code != 2'b11); // R3
  AST_FIX_ONLY_ON_REPAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fix_en) |-> (out_code == 2'b01 || (out_code == 2'b10 && !out_stage))); // R9
  AST_S2_CLEAN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_stage && in_err_cnt == '0) |=> (out_code == 2'b00 && !out_fix_en)); // R5
  AST_S2_MANY_FEW_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_stage && in_err_cnt >= E_THREE && in_flag_cnt <= F_TWO) |=> out_code == 2'b10); // R8
  AST_STAGE_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_stage == $past(in_stage)); // R10
endmodule

bind efa_flag_arbiter efa_flag_arbiter_chk #(.ERR_W(ERR_W), .FLAG_W(FLAG_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_ready   (in_ready),
  .in_stage   (in_stage),
  .in_err_cnt (in_err_cnt),
  .in_flag_cnt(in_flag_cnt),
  .out_valid  (out_valid),
  .out_code   (out_code),
  .out_fix_en (out_fix_en),
  .out_stage  (out_stage),
  .accept     (accept),
  .stall      (stall)
);

// File: tb/efa_flag_arbiter_tb_top.sv
module efa_flag_arbiter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic       in_stage = 1'b0;
  logic [2:0] in_err_cnt = '0;
  logic [4:0] in_flag_cnt = '0;
  logic       in_pos_match = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [1:0] out_code;
  logic       out_fix_en;
  logic       out_stage;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  efa_flag_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_stage(in_stage), .in_err_cnt(in_err_cnt), .in_flag_cnt(in_flag_cnt),
    .in_pos_match(in_pos_match), .out_valid(out_valid), .out_ready(out_ready),
    .out_code(out_code), .out_fix_en(out_fix_en), .out_stage(out_stage)
  );

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // returns {code, fix}
  function automatic int model(input int st, input int e, input int f, input int m);
    int code, fix;
    if (st == 0) begin
      code = (e == 0) ? 0 : (e == 1) ? 1 : 2;
      fix  = (e == 1 || e == 2) ? 1 : 0;
    end else if (e < 2) begin
      code = e;
      fix  = e;
    end else if (e == 2) begin
      code = (f >= (m != 0 ? 7 : 6)) ? 3 : (m != 0 ? 1 : 2);
      fix  = (code == 1) ? 1 : 0;
    end else begin
      code = (f > 2) ? 3 : 2;
      fix  = 0;
    end
    return code * 2 + fix;
  endfunction

  function automatic string tag(input int st, input int e, input int m);
    if (st == 0) return (e >= 3) ? "R4" : "R3";
    if (e < 2)   return "R5";
    if (e == 2)  return (m != 0) ? "R6" : "R7";
    return "R8";
  endfunction

  task automatic drive(input int st, input int e, input int f, input int m);
    in_valid     = 1'b1;
    in_stage     = st[0];
    in_err_cnt   = 3'(e);
    in_flag_cnt  = 5'(f);
    in_pos_match = m[0];
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", int'(out_valid), 0);
    check("R1", int'(out_code), 0);
    check("R1", int'(out_fix_en), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(out_valid), 0);

    // full sweep
    for (int st = 0; st < 2; st++)
      for (int e = 0; e < 8; e++)
        for (int f = 0; f < 32; f++)
          for (int m = 0; m < 2; m++) begin
            int ex;
            drive(st, e, f, m);
            check("R2", int'(in_ready), 1);
            @(negedge clk);
            in_valid = 1'b0;
            ex = model(st, e, f, m);
            check("R2", int'(out_valid), 1);
            check(tag(st, e, m), int'(out_code), ex / 2);
            check("R9", int'(out_fix_en), ex % 2);
            check("R10", int'(out_stage), st);
          end

    // backpressure: hold first decision, queue a second
    @(negedge clk);
    out_ready = 1'b0;
    drive(1, 2, 7, 1);
    @(negedge clk);
    drive(0, 2, 0, 0);
    check("R2", int'(in_ready), 0);
    @(negedge clk);
    @(negedge clk);
    check("R2", int'(out_valid), 1);
    check("R2", int'(out_code), 3);
    check("R2", int'(out_stage), 1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2", int'(out_code), 2);
    check("R9", int'(out_fix_en), 1);
    check("R10", int'(out_stage), 0);
    @(negedge clk);
    check("R2", int'(out_valid), 0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule